// File: doc/BRIEF.md
# Non-Restoring Array Divider

This block divides one unsigned magnitude by another in a single pass through combinational logic. Each operand is widened by a sign bit on the left. A grid of cells then runs radix-2 non-restoring division. Each cell is a full adder whose divisor input passes through an XOR, so one control line turns the cell into an adder or a subtractor. The divisor enters every row unchanged. The dividend bits join the partial remainder one row at a time. The effect is that the divisor walks one place to the right against the fixed dividend on each row.

There are N+1 rows, and each row is N+1 cells wide. The carry out of a row's leftmost cell gives that row's quotient bit. That bit also tells the next row whether to add or to subtract. The top row has no earlier bit, so it always subtracts. The partial remainder from the bottom row can be negative. An optional last row adds the divisor back in that case. A parameter turns this correction on or off, which suits a design that takes the raw partial remainder and fixes it elsewhere. The result is valid only when the divisor is not zero. With a zero divisor the outputs carry no meaning.

Top module: `nrd_array_divider`

## Requirements
- R1: With a nonzero divisor, `quotient` equals floor(dividend / divisor).
- R2: With correction enabled (FIX_REM = 1) and a nonzero divisor, `remainder[N-1:0]` equals dividend mod divisor. In that case `remainder[N]` is 0, and the remainder is below the divisor.
- R3: With correction disabled (FIX_REM = 0), `remainder` carries the array's last partial remainder as an (N+1)-bit two's complement value. If the quotient LSB is 1, this value is the true remainder. If the quotient LSB is 0, it is (true remainder − divisor) mod 2^(N+1).
- R4: Row 0 always subtracts. Each later row subtracts when the row above it produced quotient bit 1 and adds when that bit was 0. With a nonzero divisor, every row's leftmost carry is 1 exactly when the sign bit of that row's sum is 0. The carry of row 0 is 0.
- R5: A zero dividend gives a zero quotient and a zero remainder.
- R6: A dividend smaller than the divisor gives a quotient of 0 and a remainder equal to the dividend.
- R7: A divisor of 1 gives a quotient equal to the dividend and a remainder of 0.
- R8: R1 and R2 hold for any operand width N. The bench checks this at N = 12.
- R9: With correction enabled, quotient × divisor + remainder equals the dividend.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dividend | input | N | Unsigned dividend magnitude |
| divisor | input | N | Unsigned divisor magnitude, must be nonzero |
| quotient | output | N | Unsigned quotient, MSB from row 1 |
| remainder | output | N+1 | Remainder. Bit N is the sign bit, which is always 0 when correction is on |

## Verification
The hardest case to reach from the ports is a negative final partial remainder. Only then does the correction row do any work, and only then does the raw output differ from the true remainder. This happens exactly when the quotient LSB is 0. The stimulus reaches it in two ways. At N = 4 it applies every pair of dividend and nonzero divisor. It also drives a second copy with correction off, so every raw negative remainder is compared against remainder − divisor. The add/subtract chaining between rows is checked along the way, because a single wrongly chosen mode in any row changes the quotient for some pair in that exhaustive sweep.

// File: rtl/ndiv_pkg.sv
package ndiv_pkg;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic addBack;   // add the divisor to the final partial remainder
  } ctrlStrobesT;

endpackage

// File: rtl/nrd_cas_cell.sv
// One controlled add/subtract cell: a + d when sub = 0, a - d (with the row's
// carry-in supplying the +1) when sub = 1.
module nrd_cas_cell (
  input  logic a,
  input  logic d,
  input  logic sub,
  input  logic cin,
  output logic s,
  output logic cout
);

  logic dEff;

  always_comb begin
    dEff = d ^ sub;
    s    = a ^ dEff ^ cin;
    cout = ((a | cin) & dEff) | (a & cin);
  end

endmodule

// File: rtl/nrd_row.sv
// A row of W cells with a ripple carry that enters at the LSB as the sub flag.
module nrd_row #(
  parameter int W = 5
) (
  input  logic [W-1:0] aIn,
  input  logic [W-1:0] dIn,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         cout
);

  logic [W:0] carry;

  assign carry[0] = sub;

  for (genvar b = 0; b < W; b++) begin : g_cell
    nrd_cas_cell cellU (
      .a   (aIn[b]),
      .d   (dIn[b]),
      .sub (sub),
      .cin (carry[b]),
      .s   (sum[b]),
      .cout(carry[b+1])
    );
  end

  assign cout = carry[W];

endmodule

// File: rtl/nrd_ctrl.sv
// Control: picks each row's add/subtract mode and the correction strobe.
module nrd_ctrl
  import ndiv_pkg::*;
#(
  parameter int N       = 8,
  parameter bit FIX_REM = 1'b1
) (
  input  logic [N-1:0] prevQ,     // quotient bits of rows 0..N-1
  input  logic         rawSign,   // sign of last partial remainder
  output logic [N:0]   rowSub,    // 1 = subtract, per row
  output ctrlStrobesT  strobes
);

  localparam bit FixOn = FIX_REM;

  // Row 0 always subtracts; row k follows the quotient bit of row k-1
  assign rowSub = {prevQ, 1'b1};

  always_comb begin
    strobes.addBack = rawSign & FixOn;
  end

endmodule

// File: rtl/nrd_array.sv
// Datapath: N+1 rows of N+1 cells plus the correction row.
module nrd_array
  import ndiv_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [N-1:0] dividend,
  input  logic [N-1:0] divisor,
  input  logic [N:0]   rowSub,
  input  ctrlStrobesT  strobes,
  output logic [N:0]   qBits,     // qBits[k] from row k
  output logic [N:0]   rawRem,
  output logic [N:0]   fixedRem
);

  localparam int W    = N + 1;
  localparam int ROWS = N + 1;

  logic [W-1:0] dExt;
  logic [W-1:0] fixAddend;
  logic [W-1:0] rowIn  [ROWS];
  logic [W-1:0] rowOut [ROWS];
  logic         fixCarry;

  assign dExt = {1'b0, divisor};

  for (genvar k = 0; k < ROWS; k++) begin : g_row
    if (k == 0) begin : g_top
      // row 0 sees only the dividend's sign bit (zero) and zero padding
      assign rowIn[k] = '0;
    end else begin : g_rest
      // previous remainder moves one place left, next dividend bit enters
      assign rowIn[k] = {rowOut[k-1][N-1:0], dividend[N-k]};
    end

    nrd_row #(.W(W)) rowU (
      .aIn (rowIn[k]),
      .dIn (dExt),
      .sub (rowSub[k]),
      .sum (rowOut[k]),
      .cout(qBits[k])
    );

    // R4: a row's leftmost carry marks a non-negative row result
    always_comb begin
      if (divisor != '0) begin
        quot_sign_chk: assert (qBits[k] == ~rowOut[k][N])
          else $error("row %0d carry disagrees with sum sign", k);
      end
    end
  end

  assign rawRem    = rowOut[ROWS-1];
  assign fixAddend = strobes.addBack ? dExt : '0;

  nrd_row #(.W(W)) fixU (
    .aIn (rawRem),
    .dIn (fixAddend),
    .sub (1'b0),
    .sum (fixedRem),
    .cout(fixCarry)
  );

  // R4: the top row's subtraction of a nonzero divisor from zero is negative
  always_comb begin
    if (divisor != '0) begin
      top_row_chk: assert (qBits[0] == 1'b0)
        else $error("row 0 produced a quotient bit of 1");
    end
  end

  // R2: adding back the divisor to a negative remainder must wrap to non-negative
  always_comb begin
    if (divisor != '0 && strobes.addBack) begin
      fix_carry_chk: assert (fixCarry == 1'b1 && fixedRem[N] == 1'b0)
        else $error("correction did not restore a non-negative remainder");
    end
  end

endmodule

// File: rtl/nrd_array_divider.sv
// Top: wires the control and the cell array together.
module nrd_array_divider
  import ndiv_pkg::*;
#(
  parameter int N       = 8,
  parameter bit FIX_REM = 1'b1
) (
  input  logic [N-1:0] dividend,
  input  logic [N-1:0] divisor,
  output logic [N-1:0] quotient,
  output logic [N:0]   remainder
);

  localparam int PW = 2 * N;

  logic [N:0]   qBits;
  logic [N:0]   rowSub;
  logic [N:0]   rawRem;
  logic [N:0]   fixedRem;
  ctrlStrobesT  strobes;

  nrd_ctrl #(.N(N), .FIX_REM(FIX_REM)) ctrlU (
    .prevQ  (qBits[N-1:0]),
    .rawSign(rawRem[N]),
    .rowSub (rowSub),
    .strobes(strobes)
  );

  nrd_array #(.N(N)) dpU (
    .dividend(dividend),
    .divisor (divisor),
    .rowSub  (rowSub),
    .strobes (strobes),
    .qBits   (qBits),
    .rawRem  (rawRem),
    .fixedRem(fixedRem)
  );

  // Row 1 gives the quotient MSB, row N the LSB
  for (genvar k = 1; k <= N; k++) begin : g_q
    assign quotient[N-k] = qBits[k];
  end

  assign remainder = fixedRem;

  logic [PW-1:0] recon;
  assign recon = PW'(quotient) * PW'(divisor) + PW'(remainder[N-1:0]);

  if (FIX_REM) begin : g_fix_chk
    always_comb begin
      if (divisor != '0) begin
        // R2
        rem_sign_chk: assert (remainder[N] == 1'b0)
          else $error("corrected remainder is negative");
        // R2
        rem_range_chk: assert (remainder[N-1:0] < divisor)
          else $error("remainder not below divisor");
        // R9
        recon_chk: assert (recon == PW'(dividend))
          else $error("quotient*divisor+remainder differs from dividend");
      end
    end
  end

endmodule

// File: tb/nrd_array_divider_test.sv
module nrd_array_divider_test;

  localparam int ClkPeriod = 10;
  localparam int NS = 4;
  localparam int NW = 12;

  logic clk = 1'b0;
  always #(ClkPeriod / 2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [NS-1:0] aS, dS, qS, qR;
  logic [NS:0]   rS, rR;
  logic [NW-1:0] aW, dW, qW;
  logic [NW:0]   rW;

  nrd_array_divider #(.N(NS), .FIX_REM(1'b1)) uut (
    .dividend(aS), .divisor(dS), .quotient(qS), .remainder(rS));

  nrd_array_divider #(.N(NS), .FIX_REM(1'b0)) uutRaw (
    .dividend(aS), .divisor(dS), .quotient(qR), .remainder(rR));

  nrd_array_divider #(.N(NW), .FIX_REM(1'b1)) uutWide (
    .dividend(aW), .divisor(dW), .quotient(qW), .remainder(rW));

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic applySmall(input int a, input int d);
    @(posedge clk);
    aS = NS'(a);
    dS = NS'(d);
    @(negedge clk);
  endtask

  // R5: zero dividend, used as the reset-like starting state
  task automatic testZero();
    for (int d = 1; d < 16; d++) begin
      applySmall(0, d);
      chk("R5", "quotient", int'(qS), 0);
      chk("R5", "remainder", int'(rS), 0);
    end
  endtask

  // R1, R2, R3, R4, R9: every pair at N = 4
  task automatic testExhaustive();
    for (int a = 0; a < 16; a++) begin
      for (int d = 1; d < 16; d++) begin
        int eq, er, eraw;
        applySmall(a, d);
        eq = a / d;
        er = a % d;
        eraw = ((eq & 1) != 0) ? er : ((er - d) & 32'h1F);
        chk("R1", "quotient", int'(qS), eq);       // R4 row modes feed every bit
        chk("R2", "remainder", int'(rS), er);
        chk("R3", "raw remainder", int'(rR), eraw);
        chk("R3", "raw quotient", int'(qR), eq);
        chk("R9", "reconstruct", int'(qS) * d + int'(rS), a);
      end
    end
  endtask

  // R6: dividend below divisor
  task automatic testSmallDividend();
    for (int d = 2; d < 16; d++) begin
      applySmall(d - 1, d);
      chk("R6", "quotient", int'(qS), 0);
      chk("R6", "remainder", int'(rS), d - 1);
    end
  endtask

  // R7: unit divisor, including all-ones dividend
  task automatic testUnitDivisor();
    for (int a = 0; a < 16; a++) begin
      applySmall(a, 1);
      chk("R7", "quotient", int'(qS), a);
      chk("R7", "remainder", int'(rS), 0);
    end
  endtask

  // R8: wider operands, random and edge values
  task automatic testWide();
    for (int i = 0; i < 400; i++) begin
      int a, d;
      a = int'($urandom_range(4095, 0));
      d = int'($urandom_range(4095, 1));
      if (i == 0) begin a = 4095; d = 4095; end
      if (i == 1) begin a = 4095; d = 1; end
      if (i == 2) begin a = 2048; d = 4095; end
      if (i == 3) begin a = 4094; d = 2047; end
      @(posedge clk);
      aW = NW'(a);
      dW = NW'(d);
      @(negedge clk);
      chk("R8", "wide quotient", int'(qW), a / d);
      chk("R8", "wide remainder", int'(rW), a % d);
    end
  endtask

  initial begin
    aS = '0; dS = 4'd1; aW = '0; dW = 12'd1;
    repeat (2) @(posedge clk);
    testZero();
    testExhaustive();
    testSmallDividend();
    testUnitDivisor();
    testWide();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule